// File: doc/BRIEF.md
# Auto-indexed carveout info register

This block is an information window that tells software where a protected memory region sits. When reset is released, the block sends a one-cycle request to the memory controller. The controller answers over a private serial link with a fixed set of configuration words. The block collects these words into a small indexed buffer and then raises a done flag.

Software sees the whole buffer through a single 32-bit register. It writes the starting slot into the low nibble. Each read returns the selected slot and moves the slot pointer forward by one, so a run of reads walks through the buffer. Slot 2 holds the lowest 256-byte unit of the region and slot 3 holds the highest. Both bounds belong to the region.

Top module: `carveout_info_window`

## Requirements
- R1: After each release of reset, `req_o` is high for exactly one cycle: the cycle after the first rising edge with `rst_n` high. It stays low after that until the next reset.
- R2: After the request, every cycle with `ser_valid_i` high shifts in one bit from `ser_data_i`. Bits arrive MSB first in 28-bit words, and the k-th word received fills slot k, for k = 0..15. `done_o` goes high on the edge that takes the last bit of slot 15 and stays high until reset.
- R3: A write with `reg_wr_i` loads the read index from `reg_wdata_i[3:0]`. Bits [31:4] of the write data have no effect.
- R4: When `done_o` is high, a read with `reg_rd_i` updates `reg_rdata_o` on the next edge. Bits [31:4] carry the slot contents and bits [3:0] carry the index that was read. The index then increments and wraps from 15 to 0. `reg_rdata_o` holds its value between reads.
- R5: While `done_o` is low, a read returns zero in bits [31:4] and the used index in bits [3:0], and the index does not change.
- R6: When a write and a read happen in the same cycle, the read uses the written index, and the index afterwards is that value plus one (when `done_o` is high).
- R7: Reset clears the index, `done_o`, `reg_rdata_o` and the buffer, and re-arms the request, so the configuration is fetched again after each reset.
- R8: Slot 2 holds the region's lower bound and slot 3 its upper bound, both in 256-byte units. The region covers the bytes from lower*256 through upper*256+255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_o | output | 1 | One-cycle configuration request to the memory controller |
| ser_valid_i | input | 1 | Serial bit strobe |
| ser_data_i | input | 1 | Serial data bit, MSB first |
| done_o | output | 1 | All slots received |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data; only [3:0] used |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 32 | Registered read data {slot, index} |

## Verification
The assertions assume that the controller sends no more strobes after the last bit of slot 15 until the next reset, and that the bus raises a read strobe for one cycle per access. The bench stays inside these limits. It sends exactly 16 words per request, with idle cycles placed at random between the bits, and it drives no strobe once the transfer is complete. The register traffic mixes writes, reads and combined write-read cycles drawn from a seeded generator, and the random write data covers the upper bits.

// File: rtl/carveout_info_window.sv
module carveout_info_window #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 28,
  localparam int IW = $clog2(ENTRIES),
  localparam int DW = WIDTH + IW,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          req_o,
  input  logic          ser_valid_i,
  input  logic          ser_data_i,
  output logic          done_o,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_rd_i,
  output logic [DW-1:0] reg_rdata_o
);

  logic             armed, req_q, done_q;
  logic [BW-1:0]    bit_cnt;
  logic [IW-1:0]    word_cnt, idx;
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] slots [ENTRIES];
  logic [DW-1:0]    rdata_q;

  wire              take     = ser_valid_i && !armed && !done_q;
  wire [WIDTH-1:0]  nxt_word = {shreg[WIDTH-2:0], ser_data_i};
  wire              last_bit = bit_cnt == BW'(WIDTH-1);
  wire              last_wrd = word_cnt == IW'(ENTRIES-1);
  wire [IW-1:0]     ridx     = reg_wr_i ? reg_wdata_i[IW-1:0] : idx;

  assign req_o       = req_q;
  assign done_o      = done_q;
  assign reg_rdata_o = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      req_q <= 1'b0;
    end else begin
      armed <= 1'b0;
      req_q <= armed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      shreg    <= '0;
      done_q   <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
    end else if (take) begin
      shreg <= nxt_word;
      if (last_bit) begin
        bit_cnt         <= '0;
        slots[word_cnt] <= nxt_word;
        word_cnt        <= word_cnt + 1'b1;
        if (last_wrd) done_q <= 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_rd_i && done_q) idx <= ridx + 1'b1;
      else if (reg_wr_i)      idx <= reg_wdata_i[IW-1:0];
      if (reg_rd_i) rdata_q <= {done_q ? slots[ridx] : {WIDTH{1'b0}}, ridx};
    end
  end

  p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  p_req_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !req_q || $past(armed));
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  p_idx_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && done_q && !reg_wr_i) |=> idx == IW'($past(idx) + 1'b1));
  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !done_q && !reg_wr_i) |=> $stable(idx));
  p_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !done_q) |=> reg_rdata_o[DW-1:IW] == '0);
  p_wr_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_wr_i) |=> reg_rdata_o[IW-1:0] == $past(reg_wdata_i[IW-1:0]));
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o));

endmodule

// File: tb/sim_carveout_info_window.sv
module sim_carveout_info_window;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ser_valid = 0, ser_data = 0, wr = 0, rd = 0;
  logic [31:0] wdata = 0;
  logic req, done;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  logic [27:0] mem [16];
  logic [3:0] m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  carveout_info_window u0 (
    .clk(clk), .rst_n(rst_n), .req_o(req), .ser_valid_i(ser_valid),
    .ser_data_i(ser_data), .done_o(done), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rd_i(rd), .reg_rdata_o(rdata));

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(logic [3:0] i, logic d);
    return {d ? mem[i] : 28'h0, i};
  endfunction

  task automatic op(logic w, logic [31:0] wv, logic r, string tag);
    logic [3:0] e;
    @(negedge clk);
    wr = w; wdata = wv; rd = r;
    e = w ? wv[3:0] : m_idx;
    @(negedge clk);
    wr = 0; rd = 0;
    if (r) begin
      chk(tag, rdata, exp_word(e, done));
      if (done) m_idx = e + 4'd1;
      else m_idx = e;
    end else if (w) m_idx = wv[3:0];
  endtask

  task automatic send_all();
    for (int k = 0; k < 16; k++)
      for (int b = 27; b >= 0; b--) begin
        @(negedge clk);
        while ($urandom_range(0, 3) == 0) begin
          ser_valid = 0;
          @(negedge clk);
        end
        ser_valid = 1; ser_data = mem[k][b];
      end
    @(negedge clk);
    ser_valid = 0;
  endtask

  task automatic reset_and_req();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R7 done cleared", done, 0);
    chk("R7 rdata cleared", rdata, 0);
    chk("R1 no req in reset", req, 0);
    rst_n = 1; m_idx = 0;
    @(negedge clk); chk("R1 req pulse", req, 1);
    @(negedge clk); chk("R1 req one cycle", req, 0);
    repeat (3) @(negedge clk);
    chk("R1 req stays low", req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 28'($urandom);
    mem[2] = 28'h0012340; mem[3] = 28'h00123FF;
    m_idx = 0;
    repeat (2) @(negedge clk);
    reset_and_req();
    // R5: before done, zero data, index stays
    op(0, 0, 1, "R5 read before done");
    op(0, 0, 1, "R5 index held");
    op(1, 32'hFFFF_FFF5, 0, "R3 write");
    op(0, 0, 1, "R3 R5 upper write bits ignored");
    op(0, 0, 1, "R5 index still held");
    op(0, 0, 0, "");
    chk("R2 not done yet", done, 0);
    send_all();
    chk("R2 done after last bit", done, 1);
    // R4: sequential reads from 14 through wrap
    op(1, 32'h0000_000E, 0, "R3 set 14");
    for (int i = 0; i < 4; i++) op(0, 0, 1, "R4 auto increment and wrap");
    // R6: write and read together
    op(1, 32'hABCD_0007, 1, "R6 same-cycle write read");
    op(0, 0, 1, "R6 increments from written index");
    // R8 region bounds
    op(1, 32'h2, 0, "R3 set 2");
    op(0, 0, 1, "R8 lower slot");
    chk("R8 lower byte", {36'h0, rdata[31:4]} << 8, 64'h1234000);
    op(0, 0, 1, "R8 upper slot");
    chk("R8 upper byte inclusive", ({36'h0, rdata[31:4]} << 8) + 255, 64'h123FFFF);
    // random mix
    for (int n = 0; n < 200; n++)
      op(1'($urandom_range(0, 2) == 0), $urandom, 1'($urandom_range(0, 1)), "R4 R6 random");
    chk("R2 done sticky", done, 1);
    // R7: reset refetch with new contents
    for (int i = 0; i < 16; i++) mem[i] = 28'($urandom);
    reset_and_req();
    op(0, 0, 1, "R7 cleared data before refetch");
    send_all();
    chk("R7 done after refetch", done, 1);
    op(1, 0, 0, "R3 set 0");
    for (int i = 0; i < 16; i++) op(0, 0, 1, "R2 R7 refetched slot");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule